// File: doc/BRIEF.md
# Counter Timebase Select With Watchdog Lock

This block is the time base of a programmable counter array: a 16-bit free-running up-counter that advances once for every enable pulse from a source chosen in a byte-wide mode register. The available sources are two prescaled versions of the system clock, the raw system clock, an overflow pulse from a neighbouring timer, falling edges on an external count pin, and an external clock divided by eight. Both external signals are brought into the system clock domain by two-flop synchronizers before they are used.

The same mode register decides whether the counter freezes while the CPU is idle, whether compare module 5 serves as a watchdog, and whether that watchdog can be switched off again before the next reset. It also masks the overflow interrupt. The watchdog is enabled out of reset. While it is enabled, the register is write-protected. The single exception is a write that turns the watchdog off, and that write is accepted only while the lock bit is clear. The match logic of the watchdog itself lives elsewhere; this block only exports its enable.

Top module: `pcnt_timebase`

## Requirements
- R1: After reset the mode register reads 0x40, the count is 0, and ovf_flag and irq are 0.
- R2: Mode bits [3:1] = 100 make the count advance by one on every system clock.
- R3: Mode bits [3:1] = 000 advance the count once per 12 system clocks, and 001 advances it once per 4 system clocks.
- R4: Mode bits [3:1] = 010 advance the count once for each clock cycle in which t0_ovf is 1.
- R5: Mode bits [3:1] = 011 advance the count once for each high-to-low transition of ext_pin, seen after a two-flop synchronizer. Each level must be held for at least 2 clocks, so the rate is at most one count per 4 clocks.
- R6: Mode bits [3:1] = 101 advance the count once for every 8 rising edges of ext_clk, seen after a two-flop synchronizer.
- R7: Mode bits [3:1] = 110 or 111 hold the count unchanged.
- R8: With mode bit 7 = 1 the count does not change while cpu_idle is 1. With bit 7 = 0, cpu_idle has no effect.
- R9: While mode bit 6 (watchdog enable) is 1 and bit 5 (lock) is 0, a write with data bit 6 = 0 clears bit 6 and leaves all other bits unchanged. A write with data bit 6 = 1 changes nothing.
- R10: Mode bit 5 is sticky until reset. While bits 6 and 5 are both 1, no write changes the register. wdog_en follows bit 6.
- R11: Mode bit 4 always reads 0. With bit 6 = 0, a write stores the other seven bits as given, except that bit 5 can only be set.
- R12: ovf_flag goes to 1 when the count wraps from 0xFFFF to 0x0000 and stays at 1 until ovf_clr is pulsed.
- R13: irq is 1 exactly when ovf_flag is 1 and mode bit 0 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the mode register |
| wr_data | input | 8 | Data for a mode register write |
| rd_data | output | 8 | Current mode register contents |
| cpu_idle | input | 1 | CPU idle indication |
| t0_ovf | input | 1 | Single-cycle overflow pulse from timer 0 |
| ext_pin | input | 1 | External count input (falling edges counted) |
| ext_clk | input | 1 | External clock (asynchronous) |
| ovf_clr | input | 1 | Clears the overflow flag |
| count | output | 16 | Counter value |
| ovf_flag | output | 1 | Counter overflow flag |
| irq | output | 1 | Overflow interrupt request |
| wdog_en | output | 1 | Watchdog enable for compare module 5 |

## Verification
A wrong source selection or a wrong prescaler phase shows up as a wrong count delta within one prescale period. The bench therefore measures deltas over whole multiples of the period, so the unknown phase does not matter. A corrupted mode register appears on rd_data in the cycle after the write that caused it. A register that accepts writes while protected shows up at once as a mismatch against a bench model of the write rules, driven with random data. A broken wrap or flag shows up one clock after the count reaches 0xFFFF, as a missing ovf_flag or a wrong irq.

// File: rtl/pcnt_pkg.sv
package pcnt_pkg;
  localparam int MODE_W = 8;
  localparam int B_IDLE = 7;
  localparam int B_WDEN = 6;
  localparam int B_LOCK = 5;
  localparam int B_UNUSED = 4;
  localparam int B_SEL_LO = 1;
  localparam int B_IRQEN = 0;
  localparam logic [MODE_W-1:0] MODE_RST = 8'h40;

  typedef enum logic [2:0] {
    SRC_DIV12   = 3'b000,
    SRC_DIV4    = 3'b001,
    SRC_T0      = 3'b010,
    SRC_PINFALL = 3'b011,
    SRC_SYS     = 3'b100,
    SRC_XDIV    = 3'b101,
    SRC_RSV6    = 3'b110,
    SRC_RSV7    = 3'b111
  } src_sel_e;
endpackage

// File: rtl/pcnt_sync.sv
module pcnt_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb sh_d = {sh_q[STAGES-2:0], d};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= {STAGES{RST_VAL}};
    else        sh_q <= sh_d;
  end

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/pcnt_mode_reg.sv
module pcnt_mode_reg
  import pcnt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [MODE_W-1:0] wr_data,
  output logic [MODE_W-1:0] mode_q
);
  logic [MODE_W-1:0] mode_d;

  always_comb begin
    mode_d = mode_q;
    if (wr_en) begin
      if (!mode_q[B_WDEN]) begin
        mode_d           = wr_data;
        mode_d[B_UNUSED] = 1'b0;
        mode_d[B_LOCK]   = mode_q[B_LOCK] | wr_data[B_LOCK];
      end else if (!mode_q[B_LOCK] && !wr_data[B_WDEN]) begin
        mode_d[B_WDEN] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_RST;
    else        mode_q <= mode_d;
  end

  // R10
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[B_WDEN] && mode_q[B_LOCK]) |=> $stable(mode_q));

  // R9
  wd_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[B_WDEN] && wr_en && wr_data[B_WDEN]) |=> $stable(mode_q));
endmodule

// File: rtl/pcnt_src_mux.sv
module pcnt_src_mux
  import pcnt_pkg::*;
#(
  parameter int PRE_DIV     = 12,
  parameter int FAST_DIV    = 4,
  parameter int XDIV        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  src_sel_e sel,
  input  logic     t0_ovf,
  input  logic     ext_pin,
  input  logic     ext_clk,
  output logic     tick
);
  localparam int PW = $clog2(PRE_DIV);
  localparam int FW = $clog2(FAST_DIV);
  localparam int XW = $clog2(XDIV);

  logic [PW-1:0] pre_q, pre_d;
  logic [FW-1:0] fast_q, fast_d;
  logic [XW-1:0] xcnt_q, xcnt_d;
  logic          pin_s, pin_prev_q;
  logic          xclk_s, xclk_prev_q;
  logic          slow_tick, fast_tick, pin_fall, xrise, xtick;

  pcnt_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pin_sync (
    .clk(clk), .rst_n(rst_n), .d(ext_pin), .q(pin_s));
  pcnt_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_xclk_sync (
    .clk(clk), .rst_n(rst_n), .d(ext_clk), .q(xclk_s));

  always_comb begin
    slow_tick = (pre_q == PW'(PRE_DIV - 1));
    fast_tick = (fast_q == FW'(FAST_DIV - 1));
    pre_d     = slow_tick ? '0 : pre_q + 1'b1;
    fast_d    = fast_tick ? '0 : fast_q + 1'b1;
    pin_fall  = pin_prev_q & ~pin_s;
    xrise     = xclk_s & ~xclk_prev_q;
    xtick     = xrise && (xcnt_q == XW'(XDIV - 1));
    xcnt_d    = xcnt_q;
    if (xrise) xcnt_d = xtick ? '0 : xcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q       <= '0;
      fast_q      <= '0;
      xcnt_q      <= '0;
      pin_prev_q  <= 1'b1;
      xclk_prev_q <= 1'b0;
    end else begin
      pre_q       <= pre_d;
      fast_q      <= fast_d;
      xcnt_q      <= xcnt_d;
      pin_prev_q  <= pin_s;
      xclk_prev_q <= xclk_s;
    end
  end

  always_comb begin
    unique case (sel)
      SRC_DIV12:   tick = slow_tick;
      SRC_DIV4:    tick = fast_tick;
      SRC_T0:      tick = t0_ovf;
      SRC_PINFALL: tick = pin_fall;
      SRC_SYS:     tick = 1'b1;
      SRC_XDIV:    tick = xtick;
      default:     tick = 1'b0;
    endcase
  end
endmodule

// File: rtl/pcnt_timebase.sv
module pcnt_timebase
  import pcnt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [MODE_W-1:0] wr_data,
  output logic [MODE_W-1:0] rd_data,
  input  logic              cpu_idle,
  input  logic              t0_ovf,
  input  logic              ext_pin,
  input  logic              ext_clk,
  input  logic              ovf_clr,
  output logic [CNT_W-1:0]  count,
  output logic              ovf_flag,
  output logic              irq,
  output logic              wdog_en
);
  logic              rst_int_n;
  logic [MODE_W-1:0] mode_q;
  src_sel_e          sel;
  logic              tick, cnt_en, wrap;
  logic [CNT_W-1:0]  count_q, count_d;
  logic              ovf_q, ovf_d;

  pcnt_sync #(.STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_int_n));

  pcnt_mode_reg u_mode (
    .clk(clk), .rst_n(rst_int_n), .wr_en(wr_en), .wr_data(wr_data), .mode_q(mode_q));

  assign sel = src_sel_e'(mode_q[B_SEL_LO +: 3]);

  pcnt_src_mux u_src (
    .clk(clk), .rst_n(rst_int_n), .sel(sel), .t0_ovf(t0_ovf),
    .ext_pin(ext_pin), .ext_clk(ext_clk), .tick(tick));

  always_comb begin
    cnt_en  = tick & ~(mode_q[B_IDLE] & cpu_idle);
    wrap    = cnt_en & (&count_q);
    count_d = cnt_en ? count_q + 1'b1 : count_q;
    ovf_d   = wrap ? 1'b1 : (ovf_clr ? 1'b0 : ovf_q);
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      count_q <= '0;
      ovf_q   <= 1'b0;
    end else begin
      count_q <= count_d;
      ovf_q   <= ovf_d;
    end
  end

  assign count    = count_q;
  assign ovf_flag = ovf_q;
  assign irq      = ovf_q & mode_q[B_IRQEN];
  assign rd_data  = mode_q;
  assign wdog_en  = mode_q[B_WDEN];

  // R8
  idle_freeze_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mode_q[B_IDLE] && cpu_idle) |=> $stable(count_q));

  // R12
  wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    ((&count_q) && tick && !(mode_q[B_IDLE] && cpu_idle)) |=> (ovf_q && count_q == '0));

  // R7
  rsv_stop_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mode_q[B_SEL_LO + 2] && mode_q[B_SEL_LO + 1]) |=> $stable(count_q));
endmodule

// File: tb/tb_pcnt_timebase.sv
module tb_pcnt_timebase;
  localparam int CLK_P = 10;
  localparam int WDOG_CYC = 190000;

  logic        clk = 1'b0;
  logic        rst_n, wr_en, cpu_idle, t0_ovf, ext_pin, ext_clk, ovf_clr;
  logic [7:0]  wr_data, rd_data;
  logic [15:0] count;
  logic        ovf_flag, irq, wdog_en;
  int          n_chk = 0;
  int          n_err = 0;
  int          cyc = 0;
  logic [7:0]  model;
  logic [15:0] c0;

  pcnt_timebase dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .cpu_idle(cpu_idle), .t0_ovf(t0_ovf), .ext_pin(ext_pin), .ext_clk(ext_clk),
    .ovf_clr(ovf_clr), .count(count), .ovf_flag(ovf_flag), .irq(irq), .wdog_en(wdog_en));

  always #(CLK_P/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WDOG_CYC) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than %0d", cyc, WDOG_CYC);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end

  function automatic logic [7:0] next_mode(input logic [7:0] cur, input logic [7:0] d);
    logic [7:0] r;
    r = cur;
    if (!cur[6]) begin
      r = d & 8'hEF;
      r[5] = cur[5] | d[5];
    end else if (!cur[5] && !d[6]) begin
      r[6] = 1'b0;
    end
    return r;
  endfunction

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    step();
    wr_en = 1'b0;
    model = next_mode(model, d);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(3);
    model = 8'h40;
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; cpu_idle = 1'b0; t0_ovf = 1'b0;
    ext_pin = 1'b1; ext_clk = 1'b0; ovf_clr = 1'b0;
    void'($urandom(32'd20240611));
    #1;
    do_reset();

    // R1 reset state
    chk("R1 mode", rd_data, 8'h40);
    chk("R1 count", count, 16'h0);
    chk("R1 ovf", ovf_flag, 1'b0);
    chk("R1 irq", irq, 1'b0);
    chk("R10 wdog_en", wdog_en, 1'b1);

    // R9 protected writes
    wr(8'hC7);
    chk("R9 ignored", rd_data, 8'h40);
    wr(8'h00);
    chk("R9 clear only", rd_data, 8'h00);
    chk("R10 wdog_en off", wdog_en, 1'b0);
    wr(8'h49);
    chk("R11 write", rd_data, 8'h49);
    wr(8'h08);
    chk("R9 only bit6", rd_data, 8'h09);

    // R11 unused bit
    wr(8'h10);
    chk("R11 bit4", rd_data, 8'h00);

    // R2 system clock
    wr(8'h08);
    c0 = count; step(37);
    chk("R2 sysclk", count, c0 + 16'd37);

    // R3 prescalers
    wr(8'h00);
    c0 = count; step(120);
    chk("R3 div12", count, c0 + 16'd10);
    wr(8'h02);
    c0 = count; step(120);
    chk("R3 div4", count, c0 + 16'd30);

    // R4 timer0 overflow
    wr(8'h04);
    c0 = count;
    for (int i = 0; i < 15; i++) begin
      t0_ovf = 1'b1; step();
      t0_ovf = 1'b0; step(2);
    end
    chk("R4 t0", count, c0 + 16'd15);

    // R5 pin falling edges
    wr(8'h06);
    step(4);
    c0 = count;
    for (int i = 0; i < 10; i++) begin
      ext_pin = 1'b0; step(4);
      ext_pin = 1'b1; step(4);
    end
    step(6);
    chk("R5 pin falls", count, c0 + 16'd10);

    // R6 external clock /8
    wr(8'h0A);
    step(4);
    c0 = count;
    for (int i = 0; i < 64; i++) begin
      ext_clk = 1'b1; step(3);
      ext_clk = 1'b0; step(3);
    end
    step(6);
    chk("R6 xclk div8", count, c0 + 16'd8);

    // R7 reserved codes
    wr(8'h0C);
    c0 = count; step(30);
    chk("R7 code6", count, c0);
    wr(8'h0E);
    t0_ovf = 1'b1;
    c0 = count; step(30);
    t0_ovf = 1'b0;
    chk("R7 code7", count, c0);

    // R8 idle control
    wr(8'h88);
    cpu_idle = 1'b1;
    c0 = count; step(20);
    chk("R8 suspended", count, c0);
    cpu_idle = 1'b0;
    c0 = count; step(20);
    chk("R8 resumed", count, c0 + 16'd20);
    wr(8'h08);
    cpu_idle = 1'b1;
    c0 = count; step(20);
    chk("R8 no effect", count, c0 + 16'd20);
    cpu_idle = 1'b0;

    // R12 / R13 overflow
    while (count != 16'hFFFF) step();
    chk("R12 before wrap", ovf_flag, 1'b0);
    step();
    chk("R12 wrap count", count, 16'h0);
    chk("R12 flag set", ovf_flag, 1'b1);
    chk("R13 masked", irq, 1'b0);
    wr(8'h09);
    chk("R13 irq", irq, 1'b1);
    step(5);
    chk("R12 flag held", ovf_flag, 1'b1);
    ovf_clr = 1'b1; step(); ovf_clr = 1'b0;
    chk("R12 cleared", ovf_flag, 1'b0);
    chk("R13 irq low", irq, 1'b0);

    // R10 lock
    wr(8'h60);
    chk("R10 locked", rd_data, 8'h60);
    wr(8'h00);
    chk("R10 clear refused", rd_data, 8'h60);
    wr(8'hFF);
    chk("R10 write refused", rd_data, 8'h60);
    do_reset();
    chk("R10 lock reset", rd_data, 8'h40);

    // R9 R10 R11 random writes against model
    for (int i = 0; i < 300; i++) begin
      logic [7:0] d;
      if (model[6] && model[5]) begin
        do_reset();
      end
      d = 8'($urandom);
      if (($urandom % 4) == 0) d[6] = 1'b0;
      if (($urandom % 3) != 0) d[5] = 1'b0;
      wr(d);
      chk("R9 R10 R11 random", rd_data, model);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule